// File: doc/BRIEF.md
# Paged Indirect PHY Register Bridge

This block is a bus master that sits between a simple request/response port and a PHY. It turns one logical read or write of a 16-bit PHY control register into the series of accesses the PHY needs. The PHY exposes its local register space through a 2 KiB paged window. Every local access therefore writes a page word first and then touches a word inside the window. The PHY control registers sit behind an indirect port made of three local registers: control, address and data. The control register carries a busy flag and a start command.

A requester presents an address, write data, a write flag and a 5-bit device select under a valid/ready handshake. The bridge takes one request at a time. It polls the busy flag with a programmable spacing between reads, loads the indirect registers and starts the transfer. For reads it polls again and fetches the result. It returns one response pulse that carries read data and an error flag. If the busy flag never clears within a bounded number of reads, the request ends with the error flag set.

Top module: `phy_reg_bridge`

## Requirements
- R1: After a synchronous reset, including one applied in the middle of a request, `req_ready` is 1 and `rsp_valid` and `mem_en` are 0.
- R2: Every downstream access other than a page write comes in the cycle right after a write to window offset 0x800. The data of that write is the page word: bits 11:7 hold the device select and bits 6:0 hold bits 15:9 of the local register address.
- R3: The local register access uses the window byte offset equal to bits 8:0 of the local address shifted left by two. Only local registers 0x80A0 (control), 0x80A1 (address) and 0x80A2 (data) are touched.
- R4: Before the address register is written, the control register is read until its bit 0 (busy) returns 0. No indirect register is written while the last control read returned busy.
- R5: A read request writes the target address to the address register and writes 0x1 to control. It then polls control until it is not busy, reads the data register, and returns bits 15:0 of that data in `rsp_rdata`.
- R6: A write request writes the address register, then the data register, then 0x3 to control (bit 1 write, bit 0 start). It issues no control read after the start.
- R7: After a control read that returns busy, the downstream port stays idle for at least `POLL_GAP` cycles before the next access.
- R8: If `MAX_POLLS` consecutive control reads in one wait phase all return busy, the request ends with `rsp_error` = 1 and `rsp_rdata` = 0. No indirect register is written in that phase and no further control read is made.
- R9: `req_ready` goes low in the cycle after a request is accepted and stays low through the response cycle. A request presented while `req_ready` is low is ignored.
- R10: `rsp_valid` is a one-cycle pulse, and `req_ready` is high in the following cycle. Successful requests have `rsp_error` = 0, and write responses carry `rsp_rdata` = 0.

Every reset in this block is synchronous and active-low. A parameter value of 0 for `POLL_GAP` or `MAX_POLLS` is not supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | PHY device select |
| req_addr | input | 16 | PHY control-register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_error | output | 1 | Busy flag never cleared |
| rsp_rdata | output | DATA_W | Read data |
| mem_en | output | 1 | Downstream access this cycle |
| mem_we | output | 1 | Downstream access is a write |
| mem_addr | output | BUS_AW | Byte offset within the PHY window |
| mem_wdata | output | BUS_DW | Downstream write data |
| mem_rdata | input | BUS_DW | Downstream read data, valid one cycle after a read |

## Verification
If the sequencer state goes wrong, the port shows it within a few cycles. It appears as a window access without a page write in front of it, a page word with the wrong device or page field, an indirect register written while busy, or a control value other than 0x1 or 0x3. If the poll pacing goes wrong, the idle gap after a busy read becomes too short, or the count of control reads per request differs from the busy pattern the PHY model was told to give. If the poll limit counter goes wrong, the error response arrives after the wrong number of reads or never arrives. A wrong handshake state shows as `req_ready` rising before the response or as a second response pulse.

// File: rtl/phyb_pkg.sv
// Shared constants, state types and address helpers for the paged
// indirect PHY register bridge. Assumes a 12-bit window byte offset.
package phyb_pkg;

    localparam int DEV_W   = 5;
    localparam int LADDR_W = 16;
    localparam int WIN_AW  = 12;

    // Page register byte offset inside the window
    localparam logic [WIN_AW-1:0]  PAGE_OFF = 12'h800;

    // Local registers forming the indirect port
    localparam logic [LADDR_W-1:0] LREG_CTL  = 16'h80A0;
    localparam logic [LADDR_W-1:0] LREG_ADDR = 16'h80A1;
    localparam logic [LADDR_W-1:0] LREG_DATA = 16'h80A2;

    // Control command values
    localparam logic [1:0] CMD_RD_START = 2'b01;
    localparam logic [1:0] CMD_WR_START = 2'b11;

    typedef enum logic [2:0] {
        BR_IDLE,
        BR_POLL,
        BR_GAP,
        BR_WADDR,
        BR_WDATA,
        BR_WCTL,
        BR_RDATA,
        BR_DONE
    } bridge_st_t;

    typedef enum logic [1:0] {
        WA_IDLE,
        WA_PAGE,
        WA_ACC,
        WA_RDLY
    } win_st_t;

    // Page word: device select above the upper local address bits
    function automatic logic [WIN_AW-1:0] page_word(
        input logic [DEV_W-1:0]   dev,
        input logic [LADDR_W-1:0] la
    );
        return {dev, la[15:9]};
    endfunction

    // Byte offset of a local register inside the window
    function automatic logic [WIN_AW-1:0] win_offset(
        input logic [LADDR_W-1:0] la
    );
        return {1'b0, la[8:0], 2'b00};
    endfunction

endpackage

// File: rtl/phyb_win_access.sv
// Performs one local PHY register access through the paged window:
// a page write to the fixed page offset, then the register access.
// Reads return data one cycle after the access (single-cycle latency).
// Assumes go is only raised while idle is high.
module phyb_win_access
    import phyb_pkg::*;
#(
    parameter int BUS_AW = 12,
    parameter int BUS_DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                op_write,
    input  logic [DEV_W-1:0]    dev,
    input  logic [LADDR_W-1:0]  laddr,
    input  logic [BUS_DW-1:0]   wdata,
    output logic                idle,
    output logic                done,
    output logic [BUS_DW-1:0]   rdata,
    output logic                mem_en,
    output logic                mem_we,
    output logic [BUS_AW-1:0]   mem_addr,
    output logic [BUS_DW-1:0]   mem_wdata,
    input  logic [BUS_DW-1:0]   mem_rdata
);

    win_st_t              st_q;
    logic                 wr_q;
    logic [DEV_W-1:0]     dev_q;
    logic [LADDR_W-1:0]   la_q;
    logic [BUS_DW-1:0]    wd_q;

    // Sequence page write, register access and read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WA_IDLE;
            wr_q  <= 1'b0;
            dev_q <= '0;
            la_q  <= '0;
            wd_q  <= '0;
        end else begin
            unique case (st_q)
                WA_IDLE: begin
                    if (go) begin
                        wr_q  <= op_write;
                        dev_q <= dev;
                        la_q  <= laddr;
                        wd_q  <= wdata;
                        st_q  <= WA_PAGE;
                    end
                end
                WA_PAGE: st_q <= WA_ACC;
                WA_ACC:  st_q <= wr_q ? WA_IDLE : WA_RDLY;
                WA_RDLY: st_q <= WA_IDLE;
                default: st_q <= WA_IDLE;
            endcase
        end
    end

    // Drive the downstream port from the current step
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (st_q == WA_PAGE) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = BUS_AW'(PAGE_OFF);
            mem_wdata = BUS_DW'(page_word(dev_q, la_q));
        end else if (st_q == WA_ACC) begin
            mem_en    = 1'b1;
            mem_we    = wr_q;
            mem_addr  = BUS_AW'(win_offset(la_q));
            mem_wdata = wr_q ? wd_q : '0;
        end
    end

    assign idle  = (st_q == WA_IDLE);
    assign done  = (st_q == WA_RDLY) || ((st_q == WA_ACC) && wr_q);
    assign rdata = mem_rdata;

endmodule

// File: rtl/phyb_poll_pacer.sv
// Paces busy polling: after each busy observation it runs an idle
// gap of GAP_CYC cycles, and counts busy reads in the current wait
// phase so the sequencer can give up after MAX_POLLS of them.
// Assumes GAP_CYC >= 1 and MAX_POLLS >= 1.
module phyb_poll_pacer #(
    parameter int GAP_CYC   = 1000,
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_clr,
    input  logic busy_seen,
    output logic gap_done,
    output logic last_poll
);

    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [GW-1:0] gap_cnt_q;
    logic          run_q;
    logic [PW-1:0] poll_cnt_q;

    // Count down the idle gap after a busy read
    always_ff @(posedge clk) begin
        if (!rst_n || phase_clr) begin
            gap_cnt_q <= '0;
            run_q     <= 1'b0;
        end else if (busy_seen) begin
            gap_cnt_q <= GW'(GAP_CYC - 1);
            run_q     <= 1'b1;
        end else if (run_q) begin
            if (gap_cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                gap_cnt_q <= gap_cnt_q - 1'b1;
            end
        end
    end

    // Count busy reads within one wait phase
    always_ff @(posedge clk) begin
        if (!rst_n || phase_clr) begin
            poll_cnt_q <= '0;
        end else if (busy_seen) begin
            poll_cnt_q <= poll_cnt_q + 1'b1;
        end
    end

    assign gap_done  = run_q && (gap_cnt_q == '0);
    assign last_poll = (poll_cnt_q == PW'(MAX_POLLS - 1));

endmodule

// File: rtl/phy_reg_bridge.sv
// Paged indirect PHY register bridge. Accepts one read or write of a
// PHY control register at a time. It polls the indirect port until
// not busy, loads address (and data), issues start, and for reads
// polls again and fetches the data register. A phase that stays busy
// for MAX_POLLS reads ends with an error response.
// Assumes BUS_AW >= 12 and DATA_W <= BUS_DW.
module phy_reg_bridge
    import phyb_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BUS_AW    = 12,
    parameter int BUS_DW    = 32,
    parameter int POLL_GAP  = 1000,
    parameter int MAX_POLLS = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [DEV_W-1:0]    req_dev,
    input  logic [LADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic                rsp_error,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_en,
    output logic                mem_we,
    output logic [BUS_AW-1:0]   mem_addr,
    output logic [BUS_DW-1:0]   mem_wdata,
    input  logic [BUS_DW-1:0]   mem_rdata
);

    bridge_st_t             st_q;
    logic                   wr_q;
    logic                   post_q;
    logic                   err_q;
    logic [DEV_W-1:0]       dev_q;
    logic [LADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]      wdata_q;
    logic [DATA_W-1:0]      rdata_q;

    logic                   lcl_go;
    logic                   lcl_wr;
    logic [LADDR_W-1:0]     lcl_addr;
    logic [BUS_DW-1:0]      lcl_wdata;
    logic                   lcl_idle;
    logic                   lcl_done;
    logic [BUS_DW-1:0]      lcl_rdata;
    logic                   access_st;
    logic                   busy_bit;
    logic                   phase_clr;
    logic                   busy_seen;
    logic                   gap_done;
    logic                   last_poll;
    logic                   sig_unused;

    assign sig_unused = ^lcl_rdata[BUS_DW-1:DATA_W];
    assign busy_bit   = lcl_rdata[0];

    // Select the local access each sequencer state needs
    always_comb begin
        access_st = 1'b1;
        lcl_wr    = 1'b0;
        lcl_addr  = LREG_CTL;
        lcl_wdata = '0;
        unique case (st_q)
            BR_POLL: begin
                lcl_addr = LREG_CTL;
            end
            BR_WADDR: begin
                lcl_wr    = 1'b1;
                lcl_addr  = LREG_ADDR;
                lcl_wdata = BUS_DW'(addr_q);
            end
            BR_WDATA: begin
                lcl_wr    = 1'b1;
                lcl_addr  = LREG_DATA;
                lcl_wdata = BUS_DW'(wdata_q);
            end
            BR_WCTL: begin
                lcl_wr    = 1'b1;
                lcl_addr  = LREG_CTL;
                lcl_wdata = BUS_DW'(wr_q ? CMD_WR_START : CMD_RD_START);
            end
            BR_RDATA: begin
                lcl_addr = LREG_DATA;
            end
            default: access_st = 1'b0;
        endcase
    end

    assign lcl_go    = access_st && lcl_idle;
    assign phase_clr = ((st_q == BR_IDLE) && req_valid)
                     || ((st_q == BR_WCTL) && lcl_done && !wr_q);
    assign busy_seen = (st_q == BR_POLL) && lcl_done && busy_bit;

    // Main sequencer: poll, load, start, optional second poll, fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= BR_IDLE;
            wr_q    <= 1'b0;
            post_q  <= 1'b0;
            err_q   <= 1'b0;
            dev_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (st_q)
                BR_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        dev_q   <= req_dev;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        post_q  <= 1'b0;
                        err_q   <= 1'b0;
                        rdata_q <= '0;
                        st_q    <= BR_POLL;
                    end
                end
                BR_POLL: begin
                    if (lcl_done) begin
                        if (busy_bit) begin
                            if (last_poll) begin
                                err_q <= 1'b1;
                                st_q  <= BR_DONE;
                            end else begin
                                st_q  <= BR_GAP;
                            end
                        end else begin
                            st_q <= post_q ? BR_RDATA : BR_WADDR;
                        end
                    end
                end
                BR_GAP: begin
                    if (gap_done) st_q <= BR_POLL;
                end
                BR_WADDR: begin
                    if (lcl_done) st_q <= wr_q ? BR_WDATA : BR_WCTL;
                end
                BR_WDATA: begin
                    if (lcl_done) st_q <= BR_WCTL;
                end
                BR_WCTL: begin
                    if (lcl_done) begin
                        if (wr_q) begin
                            st_q <= BR_DONE;
                        end else begin
                            post_q <= 1'b1;
                            st_q   <= BR_POLL;
                        end
                    end
                end
                BR_RDATA: begin
                    if (lcl_done) begin
                        rdata_q <= lcl_rdata[DATA_W-1:0];
                        st_q    <= BR_DONE;
                    end
                end
                BR_DONE: st_q <= BR_IDLE;
                default: st_q <= BR_IDLE;
            endcase
        end
    end

    assign req_ready = (st_q == BR_IDLE);
    assign rsp_valid = (st_q == BR_DONE);
    assign rsp_error = (st_q == BR_DONE) && err_q;
    assign rsp_rdata = rdata_q;

    phyb_win_access #(
        .BUS_AW (BUS_AW),
        .BUS_DW (BUS_DW)
    ) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (lcl_go),
        .op_write  (lcl_wr),
        .dev       (dev_q),
        .laddr     (lcl_addr),
        .wdata     (lcl_wdata),
        .idle      (lcl_idle),
        .done      (lcl_done),
        .rdata     (lcl_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    phyb_poll_pacer #(
        .GAP_CYC   (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_clr (phase_clr),
        .busy_seen (busy_seen),
        .gap_done  (gap_done),
        .last_poll (last_poll)
    );

endmodule

// File: rtl/phy_reg_bridge_chk.sv
// Port-level protocol checks for the PHY register bridge, attached
// by bind. Observes only top-level ports.
module phy_reg_bridge_chk #(
    parameter int DATA_W = 16,
    parameter int BUS_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_error,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mem_en,
    input logic              mem_we,
    input logic [BUS_AW-1:0] mem_addr
);

    AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (mem_addr != BUS_AW'(12'h800)))
        |-> $past(mem_en && mem_we && (mem_addr == BUS_AW'(12'h800)))); // R2

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R10

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> (rsp_rdata == '0)); // R8

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_en); // R1

endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(
    .DATA_W (DATA_W),
    .BUS_AW (BUS_AW)
) chk_i (.*);

// File: tb/phy_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module phy_reg_bridge_tb_top;

    localparam int DATA_W = 16;
    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;
    localparam int GAP    = 3;
    localparam int MAXP   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [4:0]        req_dev = '0;
    logic [15:0]       req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_error;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_en;
    logic              mem_we;
    logic [BUS_AW-1:0] mem_addr;
    logic [BUS_DW-1:0] mem_wdata;
    logic [BUS_DW-1:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    phy_reg_bridge #(
        .DATA_W(DATA_W), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW),
        .POLL_GAP(GAP), .MAX_POLLS(MAXP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'hA000 ^ 16'(i * 263);
    endfunction

    // ---------------- PHY model ----------------
    logic        cfg_load = 1'b0;
    int          cfg_pre = 0;
    int          cfg_post = 0;
    logic        cur_wr = 1'b0;
    logic [4:0]  cur_dev = '0;
    logic [15:0] cur_addr = '0;
    logic [15:0] cur_data = '0;

    logic [15:0] model_mem [256];
    logic [15:0] exp_mem [256];
    logic [11:0] page_q = '0;
    logic        page_fresh = 1'b0;
    logic [15:0] la_m;
    logic [15:0] m_addr = '0;
    logic [15:0] m_data = '0;
    int  busy_left = 0;
    int  n_ctl_rd = 0;
    int  n_idx_wr = 0;
    int  page_viol = 0;
    int  off_viol = 0;
    int  order_viol = 0;
    int  min_idle = 1000000;
    int  busy_cyc = 0;
    int  cyc = 0;
    logic pend_gap = 1'b0;
    logic ready_seen = 1'b0;
    logic addr_done = 1'b0;
    logic data_done = 1'b0;
    logic started = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = init_val(i);
            exp_mem[i]   = init_val(i);
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        mem_rdata <= '0;
        if (cfg_load) begin
            busy_left = cfg_pre; n_ctl_rd = 0; n_idx_wr = 0;
            ready_seen = 0; addr_done = 0; data_done = 0; started = 0;
        end
        if (!rst_n) begin
            page_fresh = 1'b0;
        end else if (mem_en) begin
            if (pend_gap) begin
                if (cyc - busy_cyc - 1 < min_idle) min_idle = cyc - busy_cyc - 1;
                pend_gap = 1'b0;
            end
            if (mem_we && mem_addr == 12'h800) begin
                page_q = mem_wdata[11:0];
                page_fresh = 1'b1;
            end else begin
                if (!page_fresh || page_q[11:7] != cur_dev) page_viol++;
                page_fresh = 1'b0;
                la_m = {page_q[6:0], mem_addr[10:2]};
                if (mem_addr[1:0] != 2'b00 || mem_addr[11]) off_viol++;
                if (la_m == 16'h80A0 && !mem_we) begin
                    n_ctl_rd++;
                    if (started && cur_wr) order_viol++;
                    if (busy_left > 0) begin
                        mem_rdata <= 32'h1;
                        busy_left--;
                        ready_seen = 1'b0;
                        pend_gap = 1'b1;
                        busy_cyc = cyc;
                    end else begin
                        mem_rdata <= 32'h0;
                        ready_seen = 1'b1;
                    end
                end else if (la_m == 16'h80A0 && mem_we) begin
                    n_idx_wr++;
                    if (!ready_seen || !addr_done || started) order_viol++;
                    if (cur_wr && (!data_done || mem_wdata != 32'h3)) order_viol++;
                    if (!cur_wr && mem_wdata != 32'h1) order_viol++;
                    if (mem_wdata == 32'h3) model_mem[m_addr[7:0]] = m_data;
                    started = 1'b1; ready_seen = 1'b0; busy_left = cfg_post;
                end else if (la_m == 16'h80A1 && mem_we) begin
                    n_idx_wr++;
                    if (!ready_seen || started || mem_wdata[15:0] != cur_addr) order_viol++;
                    m_addr = mem_wdata[15:0]; addr_done = 1'b1;
                end else if (la_m == 16'h80A2 && mem_we) begin
                    n_idx_wr++;
                    if (!ready_seen || !addr_done || !cur_wr || started ||
                        mem_wdata[15:0] != cur_data) order_viol++;
                    m_data = mem_wdata[15:0]; data_done = 1'b1;
                end else if (la_m == 16'h80A2 && !mem_we) begin
                    if (!started || !ready_seen || cur_wr) order_viol++;
                    mem_rdata <= {16'h0, model_mem[m_addr[7:0]]};
                end else begin
                    off_viol++;
                end
            end
        end else begin
            page_fresh = 1'b0;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0 && mem_en == 1'b0, "R1", "rsp_valid/mem_en after reset",
              {rsp_valid, mem_en}, 0);
    endtask

    // One request; pre/post = busy reads the model gives before/after start
    task automatic do_req(input logic wr, input logic [4:0] dev, input logic [15:0] addr,
                          input logic [15:0] data, input int pre, input int post,
                          input logic junk);
        int pv0, ov0, qv0, wait_n;
        logic exp_err;
        int exp_ctl;
        logic [15:0] exp_rd;
        logic [7:0] jidx;
        pv0 = page_viol; ov0 = off_viol; qv0 = order_viol;
        exp_err = (pre >= MAXP) || (!wr && post >= MAXP);
        if (pre >= MAXP)  exp_ctl = MAXP;
        else if (wr)      exp_ctl = pre + 1;
        else if (exp_err) exp_ctl = pre + 1 + MAXP;
        else              exp_ctl = pre + post + 2;
        exp_rd = (wr || exp_err) ? 16'h0 : exp_mem[addr[7:0]];
        jidx = addr[7:0] ^ 8'h5A;
        @(negedge clk);
        cur_wr = wr; cur_dev = dev; cur_addr = addr; cur_data = data;
        cfg_pre = pre; cfg_post = post; cfg_load = 1'b1;
        req_valid = 1'b1; req_write = wr; req_dev = dev; req_addr = addr; req_wdata = data;
        @(negedge clk);
        cfg_load = 1'b0;
        if (junk) begin
            // R9: request presented while busy must be ignored
            req_write = 1'b1; req_addr = {8'h00, jidx}; req_wdata = 16'hDEAD;
            check(req_ready == 1'b0, "R9", "ready low after accept", req_ready, 0);
            repeat (2) @(negedge clk);
        end
        req_valid = 1'b0;
        wait_n = 0;
        while (!rsp_valid && wait_n < 4000) begin
            if (req_ready) begin
                check(1'b0, "R9", "ready high before response", 1, 0);
            end
            @(negedge clk);
            wait_n++;
        end
        check(rsp_valid == 1'b1, "R10", "response arrives", rsp_valid, 1);
        check(req_ready == 1'b0, "R9", "ready low in response cycle", req_ready, 0);
        check(rsp_error == exp_err, exp_err ? "R8" : "R10", "rsp_error", rsp_error, exp_err);
        check(rsp_rdata == exp_rd, wr ? "R10" : (exp_err ? "R8" : "R5"), "rsp_rdata",
              rsp_rdata, exp_rd);
        check(n_ctl_rd == exp_ctl, wr ? "R6" : (exp_err ? "R8" : "R4"), "control read count",
              n_ctl_rd, exp_ctl);
        if (pre >= MAXP)
            check(n_idx_wr == 0, "R8", "no indirect write after timeout", n_idx_wr, 0);
        check(page_viol == pv0, "R2", "page word violations", page_viol - pv0, 0);
        check(off_viol == ov0, "R3", "window offset violations", off_viol - ov0, 0);
        check(order_viol == qv0, wr ? "R6" : "R5", "sequence violations", order_viol - qv0, 0);
        if (wr && !exp_err) begin
            exp_mem[addr[7:0]] = data;
            check(model_mem[addr[7:0]] == data, "R6", "indirect write landed",
                  model_mem[addr[7:0]], data);
        end
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10", "pulse ends, ready back",
              {rsp_valid, req_ready}, 2'b01);
        if (junk)
            check(model_mem[jidx] == exp_mem[jidx], "R9", "ignored request wrote nothing",
                  model_mem[jidx], exp_mem[jidx]);
    endtask

    // ---------------- watchdog ----------------
    logic done_flag = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        do_reset();                                             // R1
        do_req(1'b1, 5'd3, 16'h0012, 16'h1234, 0, 0, 1'b0);    // R6 no busy
        do_req(1'b0, 5'd3, 16'h0012, 16'h0000, 0, 0, 1'b0);    // R5 read back
        do_req(1'b0, 5'd31, 16'hFE40, 16'h0000, 2, 3, 1'b1);   // R5 R7 R9
        do_req(1'b1, 5'd0, 16'h8001, 16'hBEEF, 4, 2, 1'b1);    // R6 max legal polls
        do_req(1'b1, 5'd7, 16'h0033, 16'h5555, MAXP + 2, 0, 1'b0); // R8 timeout pre
        do_req(1'b0, 5'd9, 16'h0044, 16'h0000, 1, MAXP + 1, 1'b0); // R8 timeout post
        do_req(1'b0, 5'd0, 16'h8001, 16'h0000, 0, 4, 1'b0);    // R5
        // Reset in the middle of a request (R1)
        @(negedge clk);
        cur_wr = 1'b0; cur_dev = 5'd2; cfg_pre = 100; cfg_post = 0; cfg_load = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_dev = 5'd2; req_addr = 16'h0001;
        @(negedge clk);
        cfg_load = 1'b0; req_valid = 1'b0;
        repeat (12) @(negedge clk);
        do_reset();
        for (int n = 0; n < 40; n++) begin
            logic wr;
            logic [15:0] a;
            wr = 1'($urandom_range(0, 1));
            a  = 16'($urandom());
            do_req(wr, 5'($urandom_range(0, 31)), a, 16'($urandom()),
                   int'($urandom_range(0, MAXP - 1)), int'($urandom_range(0, MAXP - 1)),
                   1'($urandom_range(0, 1)));
        end
        check(min_idle >= GAP, "R7", "idle cycles after busy read", min_idle, GAP);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule